// File: doc/BRIEF.md
# Multicycle Datapath Control Sequencer

This block is the finite-state controller for a 16-bit datapath built around a single shared bus. Each instruction goes through a three-step fetch, one decode step, and then a fixed chain of register transfers for its own opcode. In every state the sequencer chooses which source drives the bus, which registers take the bus value, and how the PC, address, destination and MDR multiplexers are set. It also sets the ALU function and the memory enable and write strobe. Memory is reached through MAR and MDR. Any step that touches memory waits there until the memory reports ready.

The sequencer reads only three things: the opcode field of the instruction register, instruction bit 11 (which picks the jump-to-subroutine form), and the memory ready signal. The registers, the ALU and the memory belong to the surrounding datapath. The instructions handled are the three operate instructions, the direct, indirect and base-plus-offset loads and stores, load-effective-address, register jump, subroutine call and trap. An opcode outside that set returns the sequencer to fetch and loads nothing.

Top module: `mc_sequencer`

## Requirements
- R1: A synchronous active-low reset, and a reset applied in the middle of an instruction, put the sequencer in the first fetch step. That step puts the PC on the bus, loads MAR, and loads the PC with its increment (pc_sel 0).
- R2: Fetch takes three steps: (a) MAR is loaded from the PC while the PC increments; (b) a memory read loads MDR from memory (mdr_sel 1, mem_en high); (c) the IR is loaded from the bus while MDR drives it. A decode step with every output low follows.
- R3: At most one bus driver is active in any state. The bus_drv bits are: bit0 PC, bit1 MDR, bit2 ALU, bit3 address path.
- R4: Operate opcodes ADD 0001, AND 0101 and NOT 1001 take one execute step. In it the ALU drives the bus and both the register file and the condition codes load. alu_op is 0, 1 or 2 for those opcodes; 3 means pass the first operand through.
- R5: LEA 1110 writes the PC-relative address (base_sel 0, off_sel 2 for the 9-bit offset) into the register and the codes in one step. LD 0010 loads MAR from that address, reads memory, then writes MDR into the register and the codes. LDR 0110 does the same from base register plus 6-bit offset (base_sel 1, off_sel 1).
- R6: LDI 1010 and STI 1011 first read a pointer at the PC-relative address. They then load MAR from MDR and finish as a load (LDI) or a store (STI) at that pointer.
- R7: ST 0011 and STR 0111 form their address (PC-relative or base-plus-offset), load MDR from the source register passed through the ALU (alu_op 3, src_sel 1, mdr_sel 0), then write memory with mem_en and mem_we both high.
- R8: The condition-code load is high only in register-write steps of ADD, AND, NOT, LD, LDI, LDR and LEA. Register writes made by the call and trap link steps leave the codes alone.
- R9: In any memory step the sequencer holds its state and outputs while mem_ready is low. It moves on at the first clock edge with mem_ready high.
- R10: JMP 1100 loads the PC from the address adder using base register and zero offset (pc_sel 1, base_sel 1, off_sel 0). JSR 0100 first writes R7 (dst_sel 1) from the PC. It then loads the PC with PC plus the 11-bit offset (off_sel 3) when bit 11 is 1, or with the base register when bit 11 is 0.
- R11: TRAP 1111 loads MAR with the zero-extended vector (address path driving, addr_sel 1), writes R7 from the PC, reads memory, then loads the PC from MDR over the bus (pc_sel 2).
- R12: Opcodes 0000, 1000 and 1101 go from decode straight back to the first fetch step, with no load enable or memory strobe asserted.
- R13: Every select or ALU code that a step does not use rests at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 4 | Opcode field of the instruction register |
| ir_long | input | 1 | Instruction bit 11: 1 selects the PC-relative call |
| mem_ready | input | 1 | Memory has completed the current access |
| bus_drv | output | 4 | One-hot bus source: PC, MDR, ALU, address path |
| ld_mar | output | 1 | Load MAR from the bus |
| ld_mdr | output | 1 | Load MDR from the source chosen by mdr_sel |
| ld_ir | output | 1 | Load the instruction register from the bus |
| ld_pc | output | 1 | Load the PC from the source chosen by pc_sel |
| ld_reg | output | 1 | Write the register file from the bus |
| ld_cc | output | 1 | Load the condition codes from the bus |
| pc_sel | output | 2 | PC source: 0 increment, 1 address adder, 2 bus |
| addr_sel | output | 1 | Address path: 0 adder, 1 zero-extended vector |
| base_sel | output | 1 | Adder base: 0 PC, 1 register |
| off_sel | output | 2 | Adder offset: 0 zero, 1 six-bit, 2 nine-bit, 3 eleven-bit |
| dst_sel | output | 1 | Destination: 0 bits 11:9, 1 R7 |
| src_sel | output | 1 | First source: 0 bits 8:6, 1 bits 11:9 |
| alu_op | output | 2 | 0 add, 1 and, 2 not, 3 pass |
| mdr_sel | output | 1 | MDR source: 0 bus, 1 memory |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write strobe |

## Verification
The assertions assume that mem_ready is meaningful only while a memory step is active, and that the opcode and bit 11 stay stable from the decode step until the instruction completes, as they would when held in the instruction register. The stimulus changes the opcode and bit 11 only in the cycle that loads the instruction register. It raises mem_ready only during memory steps, after a programmed wait of zero to two cycles, for every opcode and both values of bit 11.

// File: rtl/seqctl_pkg.sv
// Package: shared state encoding, opcode codes, bus source indices and
// select codes for the multicycle sequencer. Assumes a 4-bit opcode field.
package seqctl_pkg;

    localparam int OPW    = 4;
    localparam int NDRV   = 4;
    localparam int SELW   = 2;
    localparam int STATEW = 5;

    typedef enum logic [STATEW-1:0] {
        S_FETCH_A, S_FETCH_RD, S_FETCH_IR, S_DECODE,
        S_OPERATE, S_LEA, S_EA_PC, S_EA_BASE,
        S_PTR_RD, S_PTR_MAR, S_LD_RD, S_LD_WB,
        S_ST_DATA, S_ST_WR, S_JMP, S_LINK, S_JSR_GO,
        S_TRAP_VEC, S_TRAP_LINK, S_TRAP_RD, S_TRAP_PC
    } state_t;

    localparam logic [OPW-1:0] OP_ADD  = 4'b0001;
    localparam logic [OPW-1:0] OP_LD   = 4'b0010;
    localparam logic [OPW-1:0] OP_ST   = 4'b0011;
    localparam logic [OPW-1:0] OP_JSR  = 4'b0100;
    localparam logic [OPW-1:0] OP_AND  = 4'b0101;
    localparam logic [OPW-1:0] OP_LDR  = 4'b0110;
    localparam logic [OPW-1:0] OP_STR  = 4'b0111;
    localparam logic [OPW-1:0] OP_NOT  = 4'b1001;
    localparam logic [OPW-1:0] OP_LDI  = 4'b1010;
    localparam logic [OPW-1:0] OP_STI  = 4'b1011;
    localparam logic [OPW-1:0] OP_JMP  = 4'b1100;
    localparam logic [OPW-1:0] OP_LEA  = 4'b1110;
    localparam logic [OPW-1:0] OP_TRAP = 4'b1111;

    // bus source bit positions
    localparam int DRV_PC   = 0;
    localparam int DRV_MDR  = 1;
    localparam int DRV_ALU  = 2;
    localparam int DRV_ADDR = 3;

    localparam logic [SELW-1:0] PC_INC  = 2'd0;
    localparam logic [SELW-1:0] PC_ADDR = 2'd1;
    localparam logic [SELW-1:0] PC_BUS  = 2'd2;

    localparam logic [SELW-1:0] OFF_ZERO = 2'd0;
    localparam logic [SELW-1:0] OFF_6    = 2'd1;
    localparam logic [SELW-1:0] OFF_9    = 2'd2;
    localparam logic [SELW-1:0] OFF_11   = 2'd3;

    localparam logic [SELW-1:0] ALU_ADD  = 2'd0;
    localparam logic [SELW-1:0] ALU_AND  = 2'd1;
    localparam logic [SELW-1:0] ALU_NOT  = 2'd2;
    localparam logic [SELW-1:0] ALU_PASS = 2'd3;

    // true for states that wait on the memory handshake
    function automatic logic is_mem_state(state_t s);
        return (s == S_FETCH_RD) || (s == S_PTR_RD) || (s == S_LD_RD) ||
               (s == S_ST_WR) || (s == S_TRAP_RD);
    endfunction

    // true for opcodes whose register write also sets the condition codes
    function automatic logic sets_codes(logic [OPW-1:0] op);
        return (op == OP_ADD) || (op == OP_AND) || (op == OP_NOT) ||
               (op == OP_LD) || (op == OP_LDI) || (op == OP_LDR) ||
               (op == OP_LEA);
    endfunction

    // true for opcodes the sequencer executes
    function automatic logic is_known(logic [OPW-1:0] op);
        return sets_codes(op) || (op == OP_ST) || (op == OP_STI) ||
               (op == OP_STR) || (op == OP_JMP) || (op == OP_JSR) ||
               (op == OP_TRAP);
    endfunction

endpackage

// File: rtl/seqctl_next.sv
// Module: state register and next-state logic. Assumes the opcode is held
// stable by the instruction register from decode to the end of the
// instruction and that mem_ready is sampled only in memory states.
module seqctl_next
    import seqctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode,
    input  logic           mem_ready,
    output state_t         state
);

    state_t nxt;

    // choose the following state from the current state, opcode and handshake
    always_comb begin
        nxt = S_FETCH_A;
        case (state)
            S_FETCH_A:   nxt = S_FETCH_RD;
            S_FETCH_RD:  nxt = mem_ready ? S_FETCH_IR : S_FETCH_RD;
            S_FETCH_IR:  nxt = S_DECODE;
            S_DECODE: begin
                case (opcode)
                    OP_ADD, OP_AND, OP_NOT:        nxt = S_OPERATE;
                    OP_LEA:                        nxt = S_LEA;
                    OP_LD, OP_ST, OP_LDI, OP_STI:  nxt = S_EA_PC;
                    OP_LDR, OP_STR:                nxt = S_EA_BASE;
                    OP_JMP:                        nxt = S_JMP;
                    OP_JSR:                        nxt = S_LINK;
                    OP_TRAP:                       nxt = S_TRAP_VEC;
                    default:                       nxt = S_FETCH_A;
                endcase
            end
            S_EA_PC: begin
                if (opcode == OP_LDI || opcode == OP_STI) nxt = S_PTR_RD;
                else if (opcode == OP_LD)                 nxt = S_LD_RD;
                else                                      nxt = S_ST_DATA;
            end
            S_EA_BASE:   nxt = (opcode == OP_LDR) ? S_LD_RD : S_ST_DATA;
            S_PTR_RD:    nxt = mem_ready ? S_PTR_MAR : S_PTR_RD;
            S_PTR_MAR:   nxt = (opcode == OP_LDI) ? S_LD_RD : S_ST_DATA;
            S_LD_RD:     nxt = mem_ready ? S_LD_WB : S_LD_RD;
            S_ST_DATA:   nxt = S_ST_WR;
            S_ST_WR:     nxt = mem_ready ? S_FETCH_A : S_ST_WR;
            S_LINK:      nxt = S_JSR_GO;
            S_TRAP_VEC:  nxt = S_TRAP_LINK;
            S_TRAP_LINK: nxt = S_TRAP_RD;
            S_TRAP_RD:   nxt = mem_ready ? S_TRAP_PC : S_TRAP_RD;
            default:     nxt = S_FETCH_A;
        endcase
    end

    // advance the state, returning to the first fetch step on reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FETCH_A;
        else        state <= nxt;
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mem_state(state) && !mem_ready) |=> (state == $past(state))); // R9

    AST_MEM_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mem_state(state) && mem_ready) |=> (state != $past(state))); // R9

    AST_UNKNOWN_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && !is_known(opcode)) |=> (state == S_FETCH_A)); // R12

    AST_RESET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state == S_FETCH_A)); // R1

endmodule

// File: rtl/seqctl_out.sv
// Module: Moore control decode. Maps each state (plus opcode in the operate
// step and bit 11 in the call step) to bus drivers, load enables, selects
// and memory strobes. Assumes unused selects may rest at their zero code.
module seqctl_out
    import seqctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  state_t          state,
    input  logic [OPW-1:0]  opcode,
    input  logic            ir_long,
    output logic [NDRV-1:0] bus_drv,
    output logic            ld_mar,
    output logic            ld_mdr,
    output logic            ld_ir,
    output logic            ld_pc,
    output logic            ld_reg,
    output logic            ld_cc,
    output logic [SELW-1:0] pc_sel,
    output logic            addr_sel,
    output logic            base_sel,
    output logic [SELW-1:0] off_sel,
    output logic            dst_sel,
    output logic            src_sel,
    output logic [SELW-1:0] alu_op,
    output logic            mdr_sel,
    output logic            mem_en,
    output logic            mem_we
);

    // produce the control word for the current step
    always_comb begin
        bus_drv = '0;  ld_mar = 1'b0; ld_mdr = 1'b0; ld_ir = 1'b0;
        ld_pc = 1'b0;  ld_reg = 1'b0; ld_cc = 1'b0;  pc_sel = PC_INC;
        addr_sel = 1'b0; base_sel = 1'b0; off_sel = OFF_ZERO;
        dst_sel = 1'b0;  src_sel = 1'b0;  alu_op = ALU_ADD;
        mdr_sel = 1'b0;  mem_en = 1'b0;   mem_we = 1'b0;
        case (state)
            S_FETCH_A: begin
                bus_drv[DRV_PC] = 1'b1; ld_mar = 1'b1; ld_pc = 1'b1;
            end
            S_FETCH_RD, S_PTR_RD, S_LD_RD, S_TRAP_RD: begin
                mem_en = 1'b1; ld_mdr = 1'b1; mdr_sel = 1'b1;
            end
            S_FETCH_IR: begin
                bus_drv[DRV_MDR] = 1'b1; ld_ir = 1'b1;
            end
            S_OPERATE: begin
                bus_drv[DRV_ALU] = 1'b1; ld_reg = 1'b1; ld_cc = 1'b1;
                case (opcode)
                    OP_AND:  alu_op = ALU_AND;
                    OP_NOT:  alu_op = ALU_NOT;
                    default: alu_op = ALU_ADD;
                endcase
            end
            S_LEA: begin
                bus_drv[DRV_ADDR] = 1'b1; ld_reg = 1'b1; ld_cc = 1'b1;
                off_sel = OFF_9;
            end
            S_EA_PC: begin
                bus_drv[DRV_ADDR] = 1'b1; ld_mar = 1'b1; off_sel = OFF_9;
            end
            S_EA_BASE: begin
                bus_drv[DRV_ADDR] = 1'b1; ld_mar = 1'b1;
                base_sel = 1'b1; off_sel = OFF_6;
            end
            S_PTR_MAR: begin
                bus_drv[DRV_MDR] = 1'b1; ld_mar = 1'b1;
            end
            S_LD_WB: begin
                bus_drv[DRV_MDR] = 1'b1; ld_reg = 1'b1; ld_cc = 1'b1;
            end
            S_ST_DATA: begin
                bus_drv[DRV_ALU] = 1'b1; ld_mdr = 1'b1;
                alu_op = ALU_PASS; src_sel = 1'b1;
            end
            S_ST_WR: begin
                mem_en = 1'b1; mem_we = 1'b1;
            end
            S_JMP: begin
                ld_pc = 1'b1; pc_sel = PC_ADDR; base_sel = 1'b1;
            end
            S_LINK, S_TRAP_LINK: begin
                bus_drv[DRV_PC] = 1'b1; ld_reg = 1'b1; dst_sel = 1'b1;
            end
            S_JSR_GO: begin
                ld_pc = 1'b1; pc_sel = PC_ADDR;
                base_sel = !ir_long;
                off_sel  = ir_long ? OFF_11 : OFF_ZERO;
            end
            S_TRAP_VEC: begin
                bus_drv[DRV_ADDR] = 1'b1; ld_mar = 1'b1; addr_sel = 1'b1;
            end
            S_TRAP_PC: begin
                bus_drv[DRV_MDR] = 1'b1; ld_pc = 1'b1; pc_sel = PC_BUS;
            end
            default: ;
        endcase
    end

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_drv)); // R3

    AST_CC_WRITERS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cc |-> (ld_reg && sets_codes(opcode))); // R8

    AST_WRITE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_en && !ld_mdr)); // R7

    AST_REG_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_reg |-> (bus_drv != '0)); // R5

endmodule

// File: rtl/mc_sequencer.sv
// Module: top of the multicycle control sequencer. Joins the state
// register with the control decode. Assumes opcode and ir_long come from
// the instruction register and mem_ready from a synchronous memory.
module mc_sequencer
    import seqctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  opcode,
    input  logic        ir_long,
    input  logic        mem_ready,
    output logic [3:0]  bus_drv,
    output logic        ld_mar,
    output logic        ld_mdr,
    output logic        ld_ir,
    output logic        ld_pc,
    output logic        ld_reg,
    output logic        ld_cc,
    output logic [1:0]  pc_sel,
    output logic        addr_sel,
    output logic        base_sel,
    output logic [1:0]  off_sel,
    output logic        dst_sel,
    output logic        src_sel,
    output logic [1:0]  alu_op,
    output logic        mdr_sel,
    output logic        mem_en,
    output logic        mem_we
);

    state_t state;

    seqctl_next i_next (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .mem_ready (mem_ready),
        .state     (state)
    );

    seqctl_out i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .opcode   (opcode),
        .ir_long  (ir_long),
        .bus_drv  (bus_drv),
        .ld_mar   (ld_mar),
        .ld_mdr   (ld_mdr),
        .ld_ir    (ld_ir),
        .ld_pc    (ld_pc),
        .ld_reg   (ld_reg),
        .ld_cc    (ld_cc),
        .pc_sel   (pc_sel),
        .addr_sel (addr_sel),
        .base_sel (base_sel),
        .off_sel  (off_sel),
        .dst_sel  (dst_sel),
        .src_sel  (src_sel),
        .alu_op   (alu_op),
        .mdr_sel  (mdr_sel),
        .mem_en   (mem_en),
        .mem_we   (mem_we)
    );

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_ready) |=> ($stable(mem_en) && $stable(mem_we) && $stable(ld_mdr))); // R9

endmodule

// File: tb/test_mc_sequencer.sv
// Bench: sweeps every opcode, both values of bit 11 and memory waits of
// zero to two cycles, comparing the full control word of every step with
// a sequence built from the requirements.
module test_mc_sequencer;

    typedef struct packed {
        logic [3:0] drv;
        logic mar, mdr, ir, pc, rg, cc;
        logic [1:0] pcs;
        logic as, bs;
        logic [1:0] os;
        logic ds, ss;
        logic [1:0] alu;
        logic ms, me, mw;
    } ctl_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] opcode = 4'd0;
    logic ir_long = 1'b0;
    logic mem_ready = 1'b0;
    logic [3:0] bus_drv;
    logic ld_mar, ld_mdr, ld_ir, ld_pc, ld_reg, ld_cc;
    logic [1:0] pc_sel, off_sel, alu_op;
    logic addr_sel, base_sel, dst_sel, src_sel, mdr_sel, mem_en, mem_we;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mc_sequencer i_mc_sequencer (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .ir_long(ir_long),
        .mem_ready(mem_ready), .bus_drv(bus_drv), .ld_mar(ld_mar),
        .ld_mdr(ld_mdr), .ld_ir(ld_ir), .ld_pc(ld_pc), .ld_reg(ld_reg),
        .ld_cc(ld_cc), .pc_sel(pc_sel), .addr_sel(addr_sel),
        .base_sel(base_sel), .off_sel(off_sel), .dst_sel(dst_sel),
        .src_sel(src_sel), .alu_op(alu_op), .mdr_sel(mdr_sel),
        .mem_en(mem_en), .mem_we(mem_we)
    );

    function automatic ctl_t actual();
        return {bus_drv, ld_mar, ld_mdr, ld_ir, ld_pc, ld_reg, ld_cc, pc_sel,
                addr_sel, base_sel, off_sel, dst_sel, src_sel, alu_op,
                mdr_sel, mem_en, mem_we};
    endfunction

    // step builders, one per register transfer named in the requirements
    function automatic ctl_t st_fetch_a();
        ctl_t c = '0; c.drv = 4'b0001; c.mar = 1; c.pc = 1; return c;
    endfunction
    function automatic ctl_t st_read();
        ctl_t c = '0; c.me = 1; c.mdr = 1; c.ms = 1; return c;
    endfunction
    function automatic ctl_t st_mdr_to(input bit ir, input bit mar, input bit rg, input bit cc);
        ctl_t c = '0; c.drv = 4'b0010; c.ir = ir; c.mar = mar; c.rg = rg; c.cc = cc; return c;
    endfunction
    function automatic ctl_t st_ea(input bit base);
        ctl_t c = '0; c.drv = 4'b1000; c.mar = 1; c.bs = base;
        c.os = base ? 2'd1 : 2'd2; return c;
    endfunction
    function automatic ctl_t st_sdata();
        ctl_t c = '0; c.drv = 4'b0100; c.mdr = 1; c.alu = 2'd3; c.ss = 1; return c;
    endfunction
    function automatic ctl_t st_write();
        ctl_t c = '0; c.me = 1; c.mw = 1; return c;
    endfunction
    function automatic ctl_t st_link();
        ctl_t c = '0; c.drv = 4'b0001; c.rg = 1; c.ds = 1; return c;
    endfunction

    function automatic int last_step(input logic [3:0] op);
        case (op)
            4'b0001, 4'b0101, 4'b1001, 4'b1110, 4'b1100: return 4;
            4'b0100: return 5;
            4'b0010, 4'b0110, 4'b0011, 4'b0111: return 6;
            4'b1111: return 7;
            4'b1010, 4'b1011: return 8;
            default: return 3;
        endcase
    endfunction

    function automatic ctl_t expect_step(input logic [3:0] op, input bit l, input int k);
        ctl_t c = '0;
        int s = k - 4;
        if (k == 0) return st_fetch_a();
        if (k == 1) return st_read();
        if (k == 2) return st_mdr_to(1, 0, 0, 0);
        if (k == 3) return c;
        case (op)
            4'b0001, 4'b0101, 4'b1001: begin
                c.drv = 4'b0100; c.rg = 1; c.cc = 1;
                c.alu = (op == 4'b0101) ? 2'd1 : (op == 4'b1001) ? 2'd2 : 2'd0;
            end
            4'b1110: begin c.drv = 4'b1000; c.rg = 1; c.cc = 1; c.os = 2'd2; end
            4'b0010, 4'b0110:
                c = (s == 0) ? st_ea(op == 4'b0110) : (s == 1) ? st_read() : st_mdr_to(0, 0, 1, 1);
            4'b0011, 4'b0111:
                c = (s == 0) ? st_ea(op == 4'b0111) : (s == 1) ? st_sdata() : st_write();
            4'b1010:
                c = (s == 0) ? st_ea(0) : (s == 1 || s == 3) ? st_read() :
                    (s == 2) ? st_mdr_to(0, 1, 0, 0) : st_mdr_to(0, 0, 1, 1);
            4'b1011:
                c = (s == 0) ? st_ea(0) : (s == 1) ? st_read() :
                    (s == 2) ? st_mdr_to(0, 1, 0, 0) : (s == 3) ? st_sdata() : st_write();
            4'b1100: begin c.pc = 1; c.pcs = 2'd1; c.bs = 1; end
            4'b0100: begin
                if (s == 0) c = st_link();
                else begin c.pc = 1; c.pcs = 2'd1; c.bs = !l; c.os = l ? 2'd3 : 2'd0; end
            end
            4'b1111: begin
                if (s == 0) begin c.drv = 4'b1000; c.mar = 1; c.as = 1; end
                else if (s == 1) c = st_link();
                else if (s == 2) c = st_read();
                else begin c.drv = 4'b0010; c.pc = 1; c.pcs = 2'd2; end
            end
            default: ;
        endcase
        return c;
    endfunction

    function automatic string tag_of(input logic [3:0] op, input int k);
        if (k < 3) return "R2";
        if (k == 3) return "R13";
        case (op)
            4'b0001, 4'b0101, 4'b1001: return "R4";
            4'b1110, 4'b0010, 4'b0110: return "R5";
            4'b1010, 4'b1011: return "R6";
            4'b0011, 4'b0111: return "R7";
            4'b1100, 4'b0100: return "R10";
            4'b1111: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit cc_op(input logic [3:0] op);
        return op inside {4'b0001, 4'b0101, 4'b1001, 4'b0010, 4'b1010, 4'b0110, 4'b1110};
    endfunction

    // run one instruction from the first fetch step to its last step
    task automatic run_instr(input logic [3:0] op, input bit l, input int dly);
        int k = 0;
        int w = 0;
        int last = last_step(op);
        while (k <= last) begin
            ctl_t a = actual();
            ctl_t e = expect_step(op, l, k);
            bit stall;
            check(a == e, (w > 0) ? "R9" : tag_of(op, k), 32'(a), 32'(e));
            check($countones(a.drv) <= 1, "R3", 32'(a.drv), 32'd1);
            if (a.rg) check(a.cc == (cc_op(op) && !a.ds), "R8", 32'(a.cc), 32'(cc_op(op) && !a.ds));
            if (k == 3 && last == 3) check(a == '0, "R12", 32'(a), 32'd0);
            if (a.me && w < dly) begin mem_ready = 1'b0; w++; stall = 1'b1; end
            else begin mem_ready = a.me; w = 0; stall = 1'b0; end
            if (k == 2) begin opcode = op; ir_long = l; end
            @(posedge clk);
            @(negedge clk);
            if (!stall) k++;
        end
        mem_ready = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(actual() == st_fetch_a(), "R1", 32'(actual()), 32'(st_fetch_a()));
        for (int op = 0; op < 16; op++)
            for (int l = 0; l < 2; l++)
                for (int d = 0; d < 3; d++)
                    run_instr(4'(op), l[0], d);
        // reset while a fetch read is stalled
        @(posedge clk); @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check(actual() == st_read(), "R9", 32'(actual()), 32'(st_read()));
            @(posedge clk); @(negedge clk);
        end
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        check(actual() == st_fetch_a(), "R1", 32'(actual()), 32'(st_fetch_a()));
        run_instr(4'b0010, 1'b0, 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule